// File: doc/BRIEF.md
# Interrupt Status, Mask and Local-Bus Timeout Unit

This block collects event pulses from the neighbouring receive/transmit framers, the bit-error-rate tester and the PCI core into a 16-bit status register. It keeps a 16-bit mask register beside it and drives one active-low, level-sensitive host interrupt. The host reads and writes both registers through a plain register port. Reading the status register clears it. If an event arrives in the same cycle as that read, the event is kept.

Two status bits belong to the local bus. One is set by a watchdog when an access strobe is not answered by the ready handshake within nine clocks. The other is set by a rising edge on the synchronised local interrupt input. A mode input picks bridge mode or configuration mode. In configuration mode the two local-bus bits are never set and never drive the interrupt. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status register and the mask register both read 0x0000 and `irq_n` is 1.
- R2: The status register is at address 0x20 and the mask register is at address 0x24. Any other address reads 0x0000. A write to 0x24 stores only bits 15, 14 and 4..0. Bits 13..5 always read 0. A mask bit of 1 unmasks its source.
- R3: Each event pulse sets its status bit at the next clock edge. The bits are: `ev_rx_align` bit 0, `ev_tx_align` bit 1, `ev_bert` bit 2, `ev_pci_serr` bit 3, `ev_pci_perr` bit 4. A set bit stays set until it is read.
- R4: A clock edge with `reg_rd` high at address 0x20 clears every status bit. Reading the mask register changes nothing.
- R5: If a set event and a clearing status read fall on the same edge, the bit is 1 after that edge.
- R6: `irq_n` is 0 exactly while some status bit and its mask bit are both 1, counting bits 15 and 14 only in bridge mode.
- R7: The access watchdog runs after an edge with `lb_strobe` high. If `lb_ready` is seen high at any of the next nine edges, no error is raised. If it is not, bit 14 is set at the ninth edge.
- R8: A new strobe during an access restarts the nine-edge window. After a timeout, no further error is raised until a new strobe arrives.
- R9: A rising edge of `lb_irq_in`, seen through a two-flop synchroniser, sets bit 15. A level that stays high does not set it again after a read.
- R10: While `bridge_mode` is 0, bits 14 and 15 do not set. Bits already set there do not pull `irq_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the local-bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bridge_mode | input | 1 | 1 = bridge mode, 0 = configuration mode |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status at 0x20) |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the current address |
| ev_rx_align | input | 1 | Receive frame-alignment change pulse |
| ev_tx_align | input | 1 | Transmit frame-alignment change pulse |
| ev_bert | input | 1 | BERT state-change pulse |
| ev_pci_serr | input | 1 | PCI system-error pulse |
| ev_pci_perr | input | 1 | PCI parity-error pulse |
| lb_strobe | input | 1 | Local-bus access start |
| lb_ready | input | 1 | Local-bus ready handshake |
| lb_irq_in | input | 1 | Asynchronous local interrupt level |
| irq_n | output | 1 | Active-low host interrupt |

## Verification
The assertions check on every cycle that the unused mask bits stay zero. They also check that the interrupt follows unmasked status, that an event beats a clearing read, that configuration mode never raises the local-bus bits, and that a timeout is raised only while an access is pending. The exact nine-edge watchdog boundary, the restart of the window, the single shot per rising edge of the local interrupt, and long random mixes of reads, writes and events checked against a reference model can only be shown by the bench's scenarios.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int STAT_W = 16;
  localparam logic [7:0] STAT_ADDR = 8'h20;
  localparam logic [7:0] MASK_ADDR = 8'h24;
  localparam int B_RXA  = 0;
  localparam int B_TXA  = 1;
  localparam int B_BERT = 2;
  localparam int B_SERR = 3;
  localparam int B_PERR = 4;
  localparam int B_LBE  = 14;
  localparam int B_LBI  = 15;
  localparam logic [STAT_W-1:0] IMPL_BITS = 16'hC01F;
  localparam logic [STAT_W-1:0] LB_BITS   = 16'hC000;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  // last synchronised stage high, one stage beyond it still low
  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/irq_lb_watchdog.sv
module irq_lb_watchdog #(
  parameter int LIMIT = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic ready,
  output logic active,
  output logic timeout
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  assign active  = act_q;
  assign timeout = act_q & ~strobe & ~ready & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (strobe) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q) begin
      if (ready || cnt_q == LAST) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              clr_all,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] mask_wdata,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      // set takes priority over the clearing read
      status <= ((clr_all ? '0 : status) | set_vec) & IMPL_BITS;
      if (mask_we) mask <= mask_wdata & IMPL_BITS;
    end
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int TIMEOUT_CYC = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bridge_mode,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              ev_rx_align,
  input  logic              ev_tx_align,
  input  logic              ev_bert,
  input  logic              ev_pci_serr,
  input  logic              ev_pci_perr,
  input  logic              lb_strobe,
  input  logic              lb_ready,
  input  logic              lb_irq_in,
  output logic              irq_n
);
  logic              wd_active, wd_timeout, lbi_rise;
  logic [STAT_W-1:0] set_vec, status_q, mask_q, gate;
  logic              hit_stat, hit_mask;

  assign hit_stat = (reg_addr == ADDR_W'(STAT_ADDR));
  assign hit_mask = (reg_addr == ADDR_W'(MASK_ADDR));

  irq_lb_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wd (
    .clk(clk), .rst_n(rst_n), .strobe(lb_strobe), .ready(lb_ready),
    .active(wd_active), .timeout(wd_timeout)
  );

  irq_edge_sync #(.STAGES(SYNC_STAGES)) u_lbi (
    .clk(clk), .rst_n(rst_n), .din(lb_irq_in), .rise(lbi_rise)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_RXA]  = ev_rx_align;
    set_vec[B_TXA]  = ev_tx_align;
    set_vec[B_BERT] = ev_bert;
    set_vec[B_SERR] = ev_pci_serr;
    set_vec[B_PERR] = ev_pci_perr;
    set_vec[B_LBE]  = wd_timeout & bridge_mode;
    set_vec[B_LBI]  = lbi_rise & bridge_mode;
  end

  irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .clr_all(reg_rd & hit_stat),
    .mask_we(reg_wr & hit_mask), .mask_wdata(reg_wdata),
    .status(status_q), .mask(mask_q)
  );

  assign gate = bridge_mode ? '1 : ~LB_BITS;
  assign irq_n = ~|(status_q & mask_q & gate);

  always_comb begin
    if (hit_stat)      reg_rdata = status_q;
    else if (hit_mask) reg_rdata = mask_q;
    else               reg_rdata = '0;
  end
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bridge_mode,
  input logic        reg_rd,
  input logic [7:0]  reg_addr,
  input logic        ev_rx_align,
  input logic        ev_bert,
  input logic        irq_n,
  input logic [15:0] stat_q,
  input logic [15:0] mask_q,
  input logic        wd_active
);
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[13:5] == 9'd0);

  a_r3_bert_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bert |=> stat_q[2]);

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 8'h20 && ev_rx_align) |=> stat_q[0]);

  a_r6_unmasked_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & mask_q & 16'h001F) != 16'd0) |-> !irq_n);

  a_r6_all_masked_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 16'd0) |-> irq_n);

  a_r10_cfg_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    !bridge_mode |=> !$rose(stat_q[14]) && !$rose(stat_q[15]));

  a_r10_cfg_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!bridge_mode && (stat_q & mask_q & 16'h001F) == 16'd0) |-> irq_n);

  a_r7_timeout_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[14]) |-> $past(wd_active));
endmodule

bind irq_status_unit irq_status_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bridge_mode(bridge_mode), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .ev_rx_align(ev_rx_align), .ev_bert(ev_bert),
  .irq_n(irq_n), .stat_q(status_q), .mask_q(mask_q), .wd_active(wd_active)
);

// File: tb/irq_status_unit_tb_top.sv
`timescale 1ns/1ps
module irq_status_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bridge_mode = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [15:0] reg_wdata = 16'h0000;
  logic [15:0] reg_rdata;
  logic        ev_rx_align = 0, ev_tx_align = 0, ev_bert = 0, ev_pci_serr = 0, ev_pci_perr = 0;
  logic        lb_strobe = 0, lb_ready = 0, lb_irq_in = 0;
  logic        irq_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam logic [7:0] A_STAT = 8'h20;
  localparam logic [7:0] A_MASK = 8'h24;

  always #2 clk = ~clk;

  irq_status_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bridge_mode(bridge_mode), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ev_rx_align(ev_rx_align), .ev_tx_align(ev_tx_align),
    .ev_bert(ev_bert), .ev_pci_serr(ev_pci_serr), .ev_pci_perr(ev_pci_perr),
    .lb_strobe(lb_strobe), .lb_ready(lb_ready), .lb_irq_in(lb_irq_in), .irq_n(irq_n)
  );

  function automatic logic [15:0] exp_next(logic [15:0] st, logic clr, logic [15:0] setv);
    return ((clr ? 16'h0 : st) | setv) & 16'hC01F;
  endfunction

  function automatic logic exp_irq_n(logic [15:0] st, logic [15:0] mk, logic br);
    return ~|(st & mk & (br ? 16'hFFFF : 16'h3FFF));
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [7:0] a, output logic [15:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_clear();
    @(negedge clk); reg_rd = 1; reg_addr = A_STAT;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic access(int ready_after);
    @(negedge clk); lb_strobe = 1;
    @(negedge clk); lb_strobe = 0;
    if (ready_after > 0) begin
      repeat (ready_after - 1) @(negedge clk);
      lb_ready = 1;
      @(negedge clk); lb_ready = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, mst, mmk;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    peek(A_STAT, v); chk("R1 status", v, 16'h0);
    peek(A_MASK, v); chk("R1 mask", v, 16'h0);
    chk("R1 irq_n", {15'd0, irq_n}, 16'h1);

    // R2 mask layout and address map
    wr(A_MASK, 16'hFFFF);
    @(negedge clk); peek(A_MASK, v); chk("R2 mask implemented bits", v, 16'hC01F);
    peek(8'h28, v); chk("R2 unmapped reads zero", v, 16'h0);

    // R5 set wins over clear
    @(negedge clk); ev_bert = 1;
    @(negedge clk); ev_bert = 0; reg_rd = 1; reg_addr = A_STAT; ev_rx_align = 1;
    @(negedge clk); reg_rd = 0; ev_rx_align = 0;
    peek(A_STAT, v); chk("R5 set wins, old bit cleared", v, 16'h0001);
    rd_clear();

    // R4 mask read does not clear
    @(negedge clk); ev_pci_perr = 1;
    @(negedge clk); ev_pci_perr = 0; reg_rd = 1; reg_addr = A_MASK;
    @(negedge clk); reg_rd = 0;
    peek(A_STAT, v); chk("R4 mask read keeps status", v, 16'h0010);
    rd_clear();
    peek(A_STAT, v); chk("R4 status read clears", v, 16'h0);

    // R7 watchdog boundary, bridge mode
    bridge_mode = 1;
    wr(A_MASK, 16'h4000);
    access(9);
    repeat (3) @(negedge clk);
    peek(A_STAT, v); chk("R7 ready at ninth edge no error", v, 16'h0);
    chk("R6 irq idle", {15'd0, irq_n}, 16'h1);
    access(10);
    peek(A_STAT, v); chk("R7 ready at tenth edge errors", v, 16'h4000);
    chk("R6 irq asserted by bit14", {15'd0, irq_n}, 16'h0);
    rd_clear();
    access(0);
    repeat (8) @(negedge clk);
    peek(A_STAT, v); chk("R7 no error before ninth edge", v, 16'h0);
    @(negedge clk);
    peek(A_STAT, v); chk("R7 error at ninth edge", v, 16'h4000);
    rd_clear();
    repeat (20) @(negedge clk);
    peek(A_STAT, v); chk("R8 no re-arm without new strobe", v, 16'h0);
    // R8 restart
    @(negedge clk); lb_strobe = 1;
    @(negedge clk); lb_strobe = 0;
    repeat (4) @(negedge clk);
    lb_strobe = 1;
    @(negedge clk); lb_strobe = 0;
    repeat (8) @(negedge clk);
    peek(A_STAT, v); chk("R8 restarted window not yet expired", v, 16'h0);
    @(negedge clk);
    peek(A_STAT, v); chk("R8 restarted window expires", v, 16'h4000);
    rd_clear();

    // R9 local interrupt edge
    wr(A_MASK, 16'h8000);
    @(negedge clk); lb_irq_in = 1;
    repeat (5) @(negedge clk);
    peek(A_STAT, v); chk("R9 rising edge sets bit15", v, 16'h8000);
    rd_clear();
    repeat (10) @(negedge clk);
    peek(A_STAT, v); chk("R9 held level does not re-set", v, 16'h0);
    lb_irq_in = 0; repeat (4) @(negedge clk);
    lb_irq_in = 1; repeat (5) @(negedge clk);
    peek(A_STAT, v); chk("R9 new edge sets again", v, 16'h8000);
    chk("R6 irq from bit15", {15'd0, irq_n}, 16'h0);

    // R10 configuration mode
    bridge_mode = 0;
    #0.5;
    chk("R10 bit15 ignored for irq", {15'd0, irq_n}, 16'h1);
    rd_clear();
    lb_irq_in = 0; repeat (4) @(negedge clk);
    lb_irq_in = 1;
    access(0);
    repeat (15) @(negedge clk);
    peek(A_STAT, v); chk("R10 no local-bus bits in config", v, 16'h0);
    lb_irq_in = 0;

    // R3/R4/R6 random mix against model, configuration mode
    wr(A_MASK, 16'h0000);
    rd_clear();
    mst = 16'h0; mmk = 16'h0;
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] setv;
      logic [7:0]  a;
      logic        r, w;
      @(negedge clk);
      // outputs from previous edge
      chk("R6 random irq_n", {15'd0, irq_n}, {15'd0, exp_irq_n(mst, mmk, 1'b0)});
      chk("R3 random status", (reg_addr == A_STAT) ? reg_rdata : mst,
          mst);
      // new stimulus
      case ($urandom_range(0, 3))
        0: a = A_STAT; 1: a = A_MASK; 2: a = 8'h28; default: a = A_STAT;
      endcase
      r = ($urandom_range(0, 7) == 0);
      w = ($urandom_range(0, 15) == 0);
      setv = '0;
      setv[0] = ($urandom_range(0, 9) == 0);
      setv[1] = ($urandom_range(0, 9) == 0);
      setv[2] = ($urandom_range(0, 9) == 0);
      setv[3] = ($urandom_range(0, 9) == 0);
      setv[4] = ($urandom_range(0, 9) == 0);
      reg_addr = a; reg_rd = r; reg_wr = w; reg_wdata = 16'($urandom());
      {ev_pci_perr, ev_pci_serr, ev_bert, ev_tx_align, ev_rx_align} = setv[4:0];
      #0.5;
      if (a == A_MASK) chk("R2 random mask read", reg_rdata, mmk);
      if (a == 8'h28)  chk("R2 random unmapped", reg_rdata, 16'h0);
      if (w && a == A_MASK) mmk = reg_wdata & 16'hC01F;
      mst = exp_next(mst, r && a == A_STAT, setv);
      @(posedge clk);
    end
    @(negedge clk);
    reg_rd = 0; reg_wr = 0;
    {ev_pci_perr, ev_pci_serr, ev_bert, ev_tx_align, ev_rx_align} = '0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule